// File: doc/BRIEF.md
# Double to Integer Converter with Selectable Overflow Policy

This unit turns a 64-bit binary floating-point value into a signed or unsigned integer of 32 or 64 bits. It sits in an execution pipe and produces one result per clock with one cycle of latency. A small code chooses the integer type, and a second code chooses how NaN and out-of-range inputs are handled. There are three policies. The legacy policy clamps and sends NaN to the type minimum. The clamping policy saturates and sends NaN to zero. The wrapping policy reduces the rounded integer modulo 2^w, which is what script engines expect from a 32-bit integer coercion.

The rounding direction comes from the caller's rounding-mode input unless the mode code forces truncation. Besides the result, the unit reports whether the destination may be written, an overflow indication for the integer side, and four status flags: rounded, inexact, invalid conversion and signalling-NaN invalid. When the invalid-exception enable is set and an invalid condition occurs, the write is suppressed and the two rounding flags are held low.

Top module: `dbl2int_cvt`

## Requirements
- R1: `conv_mode[2:1]` picks the policy: 00 legacy, 01 clamping, 10 wrapping. The code 11 (modes 6 and 7) raises `illegal_mode`, and drives `wr_en`, `ovf`, every flag and `result` to 0.
- R2: Truncation toward zero applies when `conv_mode[0]` is 1 or when `rnd_mode` is 01. Otherwise `rnd_mode` 00 rounds to nearest with ties to even, 10 rounds toward +infinity and 11 rounds toward -infinity. Example: 2.5 gives 2, 3, 2 and 2 under 00, 10, 11 and 01.
- R3: `int_type[0]` = 1 selects an unsigned type and `int_type[1]` = 1 selects 64 bits (00 signed 32, 01 unsigned 32, 10 signed 64, 11 unsigned 64). A 32-bit result is sign-extended (signed) or zero-extended (unsigned) from bit 31 to 64 bits.
- R4: Under the legacy policy, NaN gives the type minimum (0 unsigned, -2^(w-1) signed). A rounded value above the range gives the type maximum, and one below the range gives the type minimum.
- R5: Under the clamping policy, NaN gives 0. Rounded values above or below the range give the type maximum or minimum.
- R6: Under the wrapping policy, NaN, both infinities and rounded magnitudes of at least 2^128 give 0. Any other value gives the rounded integer modulo 2^w, extended as in R3.
- R7: `ovf` and `flag_cvi` are set when the input is NaN or the returned integer differs from the rounded value. In that case `flag_rounded` and `flag_inexact` are 0.
- R8: When R7 does not apply, `flag_inexact` is 1 exactly when the input is not an integer. `flag_rounded` is 1 exactly when the result's magnitude is larger than the input's magnitude.
- R9: `flag_snan` is 1 for a NaN whose quiet bit (bit 51) is 0. `flag_cvi` is also 1 for such an input.
- R10: For a legal mode, `wr_en` is 0 when `flag_cvi` is raised while `inv_trap_en` is 1, and `wr_en` is 1 in every other case.
- R11: All outputs are registered and appear one clock after the inputs. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 64 | Binary64 source operand |
| int_type | input | 2 | Target integer type code |
| conv_mode | input | 3 | Policy and truncation-override code |
| rnd_mode | input | 2 | Caller's rounding direction |
| inv_trap_en | input | 1 | Invalid-operation exception enable |
| result | output | 64 | Converted integer |
| wr_en | output | 1 | Destination may be written |
| ovf | output | 1 | Integer overflow indication |
| flag_rounded | output | 1 | Magnitude was increased by rounding |
| flag_inexact | output | 1 | Result differs from the source |
| flag_cvi | output | 1 | Invalid conversion |
| flag_snan | output | 1 | Signalling-NaN invalid |
| illegal_mode | output | 1 | Mode code 6 or 7 was given |

## Verification
Some properties are checked on every cycle. The illegal-mode outputs stay quiet. Overflow excludes the rounding flags, and rounded implies inexact. A signalling NaN implies invalid. The write enable follows the invalid flag and the exception enable. A NaN under the clamping policy gives 0, truncation never raises the rounded flag, and the upper word of a 32-bit result is a correct extension. The values themselves can only be shown by the bench's sweep against its floating-point model. That sweep covers the exact saturation and wrap values, the tie-breaking of nearest-even, the boundaries one unit in the last place either side of each type limit, and large magnitudes near 2^64, 2^70 and 2^128.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int DW         = 64;
    localparam int NARROW_W   = 32;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int MAN_W      = FRAC_W + 1;
    localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
    localparam int SHIFT_BIAS = BIAS + FRAC_W;
    localparam int MAG_W      = 128;
    localparam int HUGE_SH    = MAG_W - MAN_W + 1;
    localparam int EXT_W      = 2 * MAN_W + 1;

    typedef enum logic [1:0] {
        POL_LEGACY = 2'b00,
        POL_CLAMP  = 2'b01,
        POL_WRAP   = 2'b10,
        POL_BAD    = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             huge;
        logic [MAG_W-1:0] mag;
        logic             guard;
        logic             sticky;
    } unpacked_t;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             huge;
        logic [MAG_W-1:0] mag;
        logic             inexact;
        logic             up;
    } rounded_t;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          wr;
        logic          ovf;
        logic          rnd;
        logic          inx;
        logic          cvi;
        logic          snan;
        logic          illegal;
    } cvt_out_t;

    function automatic logic [DW-1:0] extend_int(input logic [DW-1:0] v,
                                                 input logic narrow,
                                                 input logic uns);
        if (!narrow)
            return v;
        if (uns)
            return {{(DW-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
        return {{(DW-NARROW_W){v[NARROW_W-1]}}, v[NARROW_W-1:0]};
    endfunction
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [DW-1:0] fp,
    output unpacked_t     u
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic [MAN_W-1:0]  man;
    logic [EXT_W-1:0]  ext_sh;
    int                sh;
    int                n;

    always_comb begin
        ex     = fp[DW-2 -: EXP_W];
        fr     = fp[FRAC_W-1:0];
        man    = {|ex, fr};
        sh     = (ex == '0) ? (1 - SHIFT_BIAS) : (int'(ex) - SHIFT_BIAS);
        n      = -sh;
        ext_sh = '0;
        u      = '0;
        u.sign = fp[DW-1];
        u.nan  = (&ex) & (|fr);
        u.snan = (&ex) & (|fr) & ~fr[FRAC_W-1];
        if (&ex) begin
            u.huge = 1'b1;
        end else if (sh >= HUGE_SH) begin
            u.huge = 1'b1;
        end else if (sh >= 0) begin
            u.mag = MAG_W'(man) << sh;
        end else if (n > MAN_W) begin
            u.sticky = |man;
        end else begin
            ext_sh   = {man, {(MAN_W+1){1'b0}}} >> n;
            u.mag    = MAG_W'(ext_sh[EXT_W-1 -: MAN_W]);
            u.guard  = ext_sh[MAN_W];
            u.sticky = |ext_sh[MAN_W-1:0];
        end
    end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  unpacked_t u,
    input  rmode_e    rmode,
    input  logic      trunc_force,
    output rounded_t  r
);
    logic inx;
    logic up;

    always_comb begin
        inx = u.guard | u.sticky;
        up  = 1'b0;
        if (!trunc_force) begin
            unique case (rmode)
                RM_NEAR: up = u.guard & (u.sticky | u.mag[0]);
                RM_UP:   up = ~u.sign & inx;
                RM_DOWN: up = u.sign & inx;
                default: up = 1'b0;
            endcase
        end
        r.sign    = u.sign;
        r.nan     = u.nan;
        r.snan    = u.snan;
        r.huge    = u.huge;
        r.mag     = u.mag + MAG_W'(up);
        r.inexact = inx;
        r.up      = up;
    end
endmodule

// File: rtl/fcvt_select.sv
module fcvt_select
    import fcvt_pkg::*;
(
    input  rounded_t   r,
    input  logic [1:0] int_type,
    input  policy_e    policy,
    input  logic       trap_en,
    output cvt_out_t   o
);
    logic             uns;
    logic             narrow;
    int               bits;
    logic [MAG_W-1:0] posmax;
    logic [MAG_W-1:0] negmax;
    logic             over;
    logic             under;
    logic             bad;
    logic [DW-1:0]    sv;
    logic [DW-1:0]    conv;
    logic [DW-1:0]    minv;

    always_comb begin
        uns    = int_type[0];
        narrow = ~int_type[1];
        bits   = narrow ? NARROW_W : DW;
        posmax = (MAG_W'(1) << (uns ? bits : bits - 1)) - MAG_W'(1);
        negmax = uns ? '0 : (MAG_W'(1) << (bits - 1));
        over   = ~r.nan & ~r.sign & (r.huge | (r.mag > posmax));
        under  = ~r.nan &  r.sign & (r.huge | (r.mag > negmax));
        bad    = r.nan | over | under;
        sv     = r.sign ? (~r.mag[DW-1:0] + DW'(1)) : r.mag[DW-1:0];
        conv   = extend_int(sv, narrow, uns);
        minv   = ~negmax[DW-1:0] + DW'(1);

        o       = '0;
        o.cvi   = bad;
        o.ovf   = bad;
        o.snan  = r.snan;
        o.wr    = ~(trap_en & bad);
        o.inx   = ~bad & r.inexact;
        o.rnd   = ~bad & r.up;
        unique case (policy)
            POL_LEGACY: begin
                if (r.nan | under) o.value = minv;
                else if (over)     o.value = posmax[DW-1:0];
                else               o.value = conv;
            end
            POL_CLAMP: begin
                if (r.nan)         o.value = '0;
                else if (under)    o.value = minv;
                else if (over)     o.value = posmax[DW-1:0];
                else               o.value = conv;
            end
            POL_WRAP: begin
                if (r.nan | r.huge) o.value = '0;
                else                o.value = conv;
            end
            default: begin
                o         = '0;
                o.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
    import fcvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] fp_in,
    input  logic [1:0]    int_type,
    input  logic [2:0]    conv_mode,
    input  logic [1:0]    rnd_mode,
    input  logic          inv_trap_en,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic          ovf,
    output logic          flag_rounded,
    output logic          flag_inexact,
    output logic          flag_cvi,
    output logic          flag_snan,
    output logic          illegal_mode
);
    unpacked_t unp;
    rounded_t  rnd;
    cvt_out_t  nxt;
    cvt_out_t  q;

    fcvt_unpack u_unpack (
        .fp (fp_in),
        .u  (unp)
    );

    fcvt_round u_round (
        .u           (unp),
        .rmode       (rmode_e'(rnd_mode)),
        .trunc_force (conv_mode[0]),
        .r           (rnd)
    );

    fcvt_select u_select (
        .r        (rnd),
        .int_type (int_type),
        .policy   (policy_e'(conv_mode[2:1])),
        .trap_en  (inv_trap_en),
        .o        (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign result       = q.value;
    assign wr_en        = q.wr;
    assign ovf          = q.ovf;
    assign flag_rounded = q.rnd;
    assign flag_inexact = q.inx;
    assign flag_cvi     = q.cvi;
    assign flag_snan    = q.snan;
    assign illegal_mode = q.illegal;
endmodule

// File: rtl/dbl2int_cvt_chk.sv
module dbl2int_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic [63:0] fp_in,
    input logic [1:0]  int_type,
    input logic [2:0]  conv_mode,
    input logic [1:0]  rnd_mode,
    input logic        inv_trap_en,
    input logic [63:0] result,
    input logic        wr_en,
    input logic        ovf,
    input logic        flag_rounded,
    input logic        flag_inexact,
    input logic        flag_cvi,
    input logic        flag_snan,
    input logic        illegal_mode
);
    logic in_nan;
    assign in_nan = (&fp_in[62:52]) & (|fp_in[51:0]);

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_mode |-> (!wr_en && !ovf && !flag_cvi && !flag_snan && result == 64'd0)); // R1

    AST_TRUNC_NO_ROUNDUP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(conv_mode[0] || rnd_mode == 2'b01)) |-> !flag_rounded); // R2

    AST_U32_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(int_type == 2'b01)) |-> (result[63:32] == 32'd0)); // R3

    AST_S32_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(int_type == 2'b00)) |-> (result[63:32] == {32{result[31]}})); // R3

    AST_CLAMP_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_nan && conv_mode[2:1] == 2'b01)) |-> (result == 64'd0 && flag_cvi)); // R5

    AST_OVF_NO_ROUND_FLAGS: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (!flag_rounded && !flag_inexact)); // R7

    AST_ROUNDED_IS_INEXACT: assert property (@(posedge clk) disable iff (rst)
        flag_rounded |-> flag_inexact); // R8

    AST_SNAN_IS_INVALID: assert property (@(posedge clk) disable iff (rst)
        flag_snan |-> flag_cvi); // R9

    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && flag_cvi && $past(inv_trap_en)) |-> !wr_en); // R10

    AST_WRITE_WHEN_VALID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !flag_cvi && !illegal_mode) |-> wr_en); // R10
endmodule

bind dbl2int_cvt dbl2int_cvt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fp_in        (fp_in),
    .int_type     (int_type),
    .conv_mode    (conv_mode),
    .rnd_mode     (rnd_mode),
    .inv_trap_en  (inv_trap_en),
    .result       (result),
    .wr_en        (wr_en),
    .ovf          (ovf),
    .flag_rounded (flag_rounded),
    .flag_inexact (flag_inexact),
    .flag_cvi     (flag_cvi),
    .flag_snan    (flag_snan),
    .illegal_mode (illegal_mode)
);

// File: tb/dbl2int_cvt_test.sv
`timescale 1ns/1ps
module dbl2int_cvt_test;
    localparam int NVALS = 39;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] fp_in = 64'd0;
    logic [1:0]  int_type = 2'd0;
    logic [2:0]  conv_mode = 3'd0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        inv_trap_en = 1'b0;
    logic [63:0] result;
    logic        wr_en, ovf, flag_rounded, flag_inexact, flag_cvi, flag_snan, illegal_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbl2int_cvt uut (
        .clk(clk), .rst(rst), .fp_in(fp_in), .int_type(int_type),
        .conv_mode(conv_mode), .rnd_mode(rnd_mode), .inv_trap_en(inv_trap_en),
        .result(result), .wr_en(wr_en), .ovf(ovf), .flag_rounded(flag_rounded),
        .flag_inexact(flag_inexact), .flag_cvi(flag_cvi), .flag_snan(flag_snan),
        .illegal_mode(illegal_mode)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: fp=%h type=%0d mode=%0d rm=%0d trap=%0d actual=%h expected=%h",
                     tag, fp_in, int_type, conv_mode, rnd_mode, inv_trap_en, act, exp);
        end
    endtask

    function automatic real p2(input int n);
        real r = 1.0;
        for (int i = 0; i < n; i++) r = r * 2.0;
        return r;
    endfunction

    function automatic logic [63:0] pick(input int i);
        case (i)
            0:  return 64'h7FF8000000000000;
            1:  return 64'h7FF0000000000001;
            2:  return 64'hFFF8000000000123;
            3:  return 64'h7FF0000000000000;
            4:  return 64'hFFF0000000000000;
            5:  return 64'h0000000000000000;
            6:  return 64'h8000000000000000;
            7:  return $realtobits(0.5);
            8:  return $realtobits(-0.5);
            9:  return $realtobits(2.5);
            10: return $realtobits(-2.5);
            11: return $realtobits(1.5);
            12: return $realtobits(-1.5);
            13: return $realtobits(0.3);
            14: return $realtobits(-0.3);
            15: return $realtobits(-123456.75);
            16: return $realtobits(2147483647.0);
            17: return $realtobits(2147483648.0);
            18: return $realtobits(2147483647.5);
            19: return $realtobits(-2147483648.0);
            20: return $realtobits(-2147483649.0);
            21: return $realtobits(-2147483648.5);
            22: return $realtobits(4294967295.0);
            23: return $realtobits(4294967296.0);
            24: return $realtobits(4294967295.5);
            25: return $realtobits(9223372036854775808.0);
            26: return $realtobits(9223372036854774784.0);
            27: return $realtobits(-9223372036854775808.0);
            28: return $realtobits(-9223372036854777856.0);
            29: return $realtobits(18446744073709551616.0);
            30: return $realtobits(18446744073709549568.0);
            31: return $realtobits(1180591620717412089856.0);
            32: return $realtobits(-1180591620717412089856.0);
            33: return 64'h47F0000000000000;
            34: return 64'h47EFFFFFFFFFFFFF;
            35: return 64'h0000000000000001;
            36: return 64'h7FEFFFFFFFFFFFFF;
            37: return $realtobits(-3.5);
            default: return $realtobits(4503599627370497.0);
        endcase
    endfunction

    function automatic logic [63:0] ext(input logic [63:0] v, input bit narrow, input bit uns);
        if (!narrow) return v;
        return uns ? {32'd0, v[31:0]} : {{32{v[31]}}, v[31:0]};
    endfunction

    task automatic model(input logic [63:0] b, input logic [1:0] it, input logic [2:0] cm,
                         input logic [1:0] rm, input bit ten,
                         output logic [63:0] ev, output bit ewr, output bit eovf,
                         output bit ernd, output bit einx, output bit esnan,
                         output bit eill, output string tag);
        bit nan, inf, neg, uns, narrow, trunc, over, under, huge;
        real x, fl, d, rnd, a;
        logic [63:0] u, maxv, minv, conv;
        int w;
        ev = 64'd0; ewr = 0; eovf = 0; ernd = 0; einx = 0; esnan = 0;
        eill = (cm[2:1] == 2'b11);
        tag = "R1";
        if (eill) return;
        nan = (&b[62:52]) && (b[51:0] != 0);
        inf = (&b[62:52]) && (b[51:0] == 0);
        neg = b[63];
        uns = it[0];
        narrow = !it[1];
        w = narrow ? 32 : 64;
        trunc = cm[0] || rm == 2'b01;
        x = 0.0; rnd = 0.0;
        if (!nan && !inf) begin
            x = $bitstoreal(b);
            fl = $floor(x);
            if (trunc) rnd = (x < 0.0) ? $ceil(x) : fl;
            else if (rm == 2'b00) begin
                d = x - fl;
                if (d > 0.5) rnd = fl + 1.0;
                else if (d < 0.5) rnd = fl;
                else rnd = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            else if (rm == 2'b10) rnd = $ceil(x);
            else rnd = fl;
        end
        over = 0; under = 0; huge = inf;
        if (inf) begin
            over = !neg; under = neg;
        end else if (!nan) begin
            huge = (rnd >= p2(128)) || (rnd <= -p2(128));
            if (uns) begin
                over = rnd >= p2(w); under = rnd < 0.0;
            end else begin
                over = rnd >= p2(w - 1); under = rnd < -p2(w - 1);
            end
        end
        maxv = uns ? (narrow ? 64'h00000000FFFFFFFF : 64'hFFFFFFFFFFFFFFFF)
                   : (narrow ? 64'h000000007FFFFFFF : 64'h7FFFFFFFFFFFFFFF);
        minv = uns ? 64'd0 : (narrow ? 64'hFFFFFFFF80000000 : 64'h8000000000000000);
        conv = 64'd0;
        if (!nan && !huge) begin
            a = (rnd < 0.0) ? -rnd : rnd;
            a = a - $floor(a / p2(64)) * p2(64);
            if (a >= p2(63)) u = 64'h8000000000000000 | 64'(longint'(a - p2(63)));
            else u = 64'(longint'(a));
            if (rnd < 0.0) u = -u;
            conv = ext(u, narrow, uns);
        end
        case (cm[2:1])
            2'b00: begin
                tag = "R4";
                if (nan || under) ev = minv; else if (over) ev = maxv; else ev = conv;
            end
            2'b01: begin
                tag = "R5";
                if (nan) ev = 0; else if (under) ev = minv; else if (over) ev = maxv; else ev = conv;
            end
            default: begin
                tag = "R6";
                ev = (nan || huge) ? 64'd0 : conv;
            end
        endcase
        if (!nan && !over && !under) tag = narrow ? "R3" : "R2";
        eovf = nan || over || under;
        esnan = nan && !b[51];
        ewr = !(ten && eovf);
        if (!eovf) begin
            einx = (rnd != x);
            ernd = (rnd < 0.0 ? -rnd : rnd) > (x < 0.0 ? -x : x);
        end
    endtask

    initial begin
        logic [63:0] ev;
        bit ewr, eovf, ernd, einx, esnan, eill;
        string tag;
        fp_in = $realtobits(2.5);
        conv_mode = 3'b100;
        inv_trap_en = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset clears every output
        chk("R11 reset", {result[62:0] | 63'(wr_en) | 63'(ovf) | 63'(flag_rounded) | 63'(flag_inexact)
                          | 63'(flag_cvi) | 63'(flag_snan) | 63'(illegal_mode), result[63]}, 64'd0);
        rst = 1'b0;
        for (int vi = 0; vi < NVALS; vi++)
            for (int ti = 0; ti < 4; ti++)
                for (int mi = 0; mi < 8; mi++)
                    for (int ri = 0; ri < 4; ri++)
                        for (int ei = 0; ei < 2; ei++) begin
                            fp_in = pick(vi);
                            int_type = 2'(ti);
                            conv_mode = 3'(mi);
                            rnd_mode = 2'(ri);
                            inv_trap_en = ei[0];
                            model(fp_in, int_type, conv_mode, rnd_mode, inv_trap_en,
                                  ev, ewr, eovf, ernd, einx, esnan, eill, tag);
                            @(negedge clk);
                            // one cycle after the inputs the outputs hold their conversion (R11)
                            chk(tag, result, ev);
                            chk("R1 illegal", 64'(illegal_mode), 64'(eill));
                            chk("R10 wr_en", 64'(wr_en), 64'(ewr));
                            chk("R7 ovf/cvi", {62'd0, ovf, flag_cvi}, {62'd0, eovf, eovf});
                            chk("R8 rounded/inexact", {62'd0, flag_rounded, flag_inexact}, {62'd0, ernd, einx});
                            chk("R9 snan", 64'(flag_snan), 64'(esnan));
                        end
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule